// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers interrupt requests from a set of I/O devices and drives one interrupt line to a processor. Every device owns one request input and one mask bit. An unmasked request is latched as pending. The controller then picks the pending device with the lowest index, because a lower index means a higher priority. That winner is signalled on `irq_o` whenever the current service state allows it.

The processor enters a handler by pulsing `ack_i`. This moves the winner from pending to in-service and exposes its identity on `id_o`, so the handler can find its source. The handler ends with a pulse on `eoi_i`. A mode input selects one of two behaviours:
- In flat mode, nothing interrupts a running handler.
- In nesting mode, a strictly higher priority may pre-empt the running handler. The in-service vector, with one bit per level, then acts as a stack of interrupted levels.

A global enable flag drops on handler entry and rises again once the last handler has returned. A combinational status word exposes the pending bits, the in-service bits, the current identity and the global enable. Reading it changes nothing.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending and in-service bits are 0, `irq_o` is 0, `id_o` is 0, `active_o` is 0 and the global enable is 1.
- R2: A request that is high and unmasked (`mask_i` bit = 0) at a clock edge sets that device's pending bit. The bit stays set after the request drops. A request whose mask bit is 1 sets nothing.
- R3: The pending device with the lowest index wins arbitration. When two requests arrive in the same cycle, the lower index is serviced first and the other stays pending.
- R4: An `ack_i` while `irq_o` is 1 (and `eoi_i` is 0) moves the winner into service at the next edge. It clears the winner's pending bit, and `id_o` then shows the winner. An `ack_i` while `irq_o` is 0 is ignored.
- R5: In flat mode (`nest_en_i` = 0), `irq_o` stays 0 while any in-service bit is set, even for a higher priority.
- R6: In nesting mode (`nest_en_i` = 1), while a handler is in service, `irq_o` rises only for a pending index strictly lower than `id_o`. Equal and lower priorities wait.
- R7: `eoi_i` clears the lowest-index in-service bit, and `id_o` falls back to the next remaining in-service index (0 when none remain). `eoi_i` with nothing in service is ignored. When `eoi_i` and `ack_i` are high together, `ack_i` is ignored.
- R8: The global enable clears on an accepted acknowledge and sets when a return empties the in-service set. While it is 0, only a nesting pre-emption can raise `irq_o`.
- R9: `status_o` holds the pending bits in [N-1:0], the in-service bits in [2N-1:N], `id_o` in [2N+ID_W-1:2N] and the global enable in bit 2N+ID_W. It is a pure function of the state and has no side effect.
- R10: Requests that arrive during a handler stay pending. After the return they are serviced one per acknowledge, in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Level request per device |
| mask_i | input | N_SRC | Per-device mask, 1 blocks latching |
| nest_en_i | input | 1 | 0 flat mode, 1 nesting mode |
| ack_i | input | 1 | Handler-entry acknowledge |
| eoi_i | input | 1 | Return-from-interrupt |
| irq_o | output | 1 | Interrupt line to the processor |
| id_o | output | ID_W | Identity of the device in service |
| active_o | output | 1 | A handler is in service |
| status_o | output | 2*N_SRC+ID_W+1 | Status word {gie, id, in_service, pending} |

## Verification
Several properties are checked on every cycle:
- The global enable always mirrors an empty in-service set.
- Flat mode never signals while a handler is in service.
- Any signal during nesting names a strictly higher level.
- An accepted acknowledge lands the winner as the visible identity.
- A cleared pending bit really is clear on the next cycle.
- Each accepted return removes exactly one in-service level.

Some behaviours need the bench's scenarios to show them. These are the order in which queued requests drain after a return, the retention of the losing request when two arrive together, the ignoring of masked requests and of stray acknowledges, and the resumption of an interrupted level after a nested return. The bench checks them against a reference model kept in bench functions.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    MODE_FLAT = 1'b0,
    MODE_NEST = 1'b1
  } mode_e;

  function automatic int stat_width(input int n, input int iw);
    return 2 * n + iw + 1;
  endfunction
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q[g] <= 1'b0;
      else if (clr_i[g])  pend_q[g] <= 1'b0;
      else if (req_i[g] && !mask_i[g]) pend_q[g] <= 1'b1;
    end

    assert_clr_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] |=> !pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [IW-1:0] push_idx_i,
  input  logic          pop_i,
  output logic [N-1:0]  isr_o,
  output logic          gie_o,
  output logic          top_vld_o,
  output logic [IW-1:0] top_idx_o
);
  logic [N-1:0] isr_q, isr_pop, isr_d;
  logic         gie_q;

  // lowest index is the highest level; clear the lowest set bit
  assign isr_pop = pop_i ? (isr_q & (isr_q - N'(1))) : isr_q;
  assign isr_d   = push_i ? (isr_pop | (N'(1) << push_idx_i)) : isr_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      gie_q <= 1'b1;
    end else begin
      isr_q <= isr_d;
      if (push_i)                         gie_q <= 1'b0;
      else if (pop_i && (isr_pop == '0))  gie_q <= 1'b1;
    end
  end

  pic_prio_find #(.N(N), .IW(IW)) u_top (
    .vec_i (isr_q),
    .vld_o (top_vld_o),
    .idx_o (top_idx_o)
  );

  assign isr_o = isr_q;
  assign gie_o = gie_q;

  assert_gie_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_q == (isr_q == '0));

  assert_pop_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ID_W   = $clog2(N_SRC),
  parameter int STAT_W = stat_width(N_SRC, ID_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [N_SRC-1:0]  mask_i,
  input  logic              nest_en_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   id_o,
  output logic              active_o,
  output logic [STAT_W-1:0] status_o
);
  mode_e             mode;
  logic [N_SRC-1:0]  pend, isr, clr;
  logic              win_vld, top_vld, gie;
  logic [ID_W-1:0]   win_idx, top_idx;
  logic              preempt_ok, push, pop;

  assign mode = mode_e'(nest_en_i);

  pic_pend #(.N(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .mask_i (mask_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  pic_prio_find #(.N(N_SRC), .IW(ID_W)) u_win (
    .vec_i (pend),
    .vld_o (win_vld),
    .idx_o (win_idx)
  );

  pic_isr #(.N(N_SRC), .IW(ID_W)) u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_idx_i (win_idx),
    .pop_i      (pop),
    .isr_o      (isr),
    .gie_o      (gie),
    .top_vld_o  (top_vld),
    .top_idx_o  (top_idx)
  );

  assign preempt_ok = (mode == MODE_NEST) && top_vld && (win_idx < top_idx);
  assign irq_o      = win_vld && (gie || preempt_ok);
  assign pop        = eoi_i && top_vld;
  assign push       = ack_i && irq_o && !eoi_i;
  assign clr        = push ? (N_SRC'(1) << win_idx) : '0;

  assign id_o     = top_idx;
  assign active_o = top_vld;
  assign status_o = {gie, top_idx, isr, pend};

  assert_flat_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_FLAT && active_o) |-> !irq_o);

  assert_nest_strict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && active_o) |-> (win_idx < id_o));

  assert_ack_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> (active_o && id_o == $past(win_idx)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N  = 8;
  localparam int IW = $clog2(N);
  localparam int SW = 2 * N + IW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, mask = '0;
  logic          nest = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic          irq, active;
  logic [IW-1:0] id;
  logic [SW-1:0] status;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  logic [N-1:0] m_pend = '0, m_isr = '0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .mask_i (mask),
    .nest_en_i (nest), .ack_i (ack), .eoi_i (eoi),
    .irq_o (irq), .id_o (id), .active_o (active), .status_o (status)
  );

  function automatic int f_low(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic f_irq(input logic [N-1:0] p, s, input logic ns);
    int w, t;
    w = f_low(p);
    t = f_low(s);
    if (w < 0) return 1'b0;
    if (s == '0) return 1'b1;
    return ns && (w < t);
  endfunction

  function automatic logic [SW-1:0] f_stat(input logic [N-1:0] p, s);
    int t;
    t = f_low(s);
    return {(s == '0), (t < 0) ? IW'(0) : IW'(t), s, p};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, mk, input logic ak, eo, ns);
    logic          e_irq, do_ack;
    logic [N-1:0]  ns_isr, clrv;
    int            w;
    req = rq; mask = mk; ack = ak; eoi = eo; nest = ns;
    #1;
    e_irq = f_irq(m_pend, m_isr, ns);
    check("R4/R5/R6 irq", 32'(irq), 32'(e_irq));
    check("R9 status", 32'(status), 32'(f_stat(m_pend, m_isr)));
    check("R7 id", 32'(id), 32'(f_stat(m_pend, m_isr)[2*N +: IW]));
    check("R7 active", 32'(active), 32'(m_isr != '0));
    @(posedge clk);
    w = f_low(m_pend);
    do_ack = ak && e_irq && !eo;
    ns_isr = m_isr;
    if (eo && m_isr != '0) ns_isr = ns_isr & ~(N'(1) << f_low(m_isr));
    clrv = '0;
    if (do_ack) begin
      clrv = N'(1) << w;
      ns_isr = ns_isr | clrv;
    end
    m_pend = (m_pend & ~clrv) | (rq & ~mk & ~clrv);
    m_isr = ns_isr;
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 status", 32'(status), 32'(1) << (2 * N + IW));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 masked request ignored, R4 stray ack, R7 stray eoi
    step(8'h08, 8'h08, 1'b0, 1'b0, 1'b0);
    check("R2 masked", 32'(status[N-1:0]), 0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R4 stray ack", 32'(active), 0);
    step('0, '0, 1'b0, 1'b1, 1'b0);
    check("R7 stray eoi gie", 32'(status[SW-1]), 1);

    // R3 simultaneous arrival
    step(8'h24, '0, 1'b0, 1'b0, 1'b0);
    check("R2 held", 32'(status[N-1:0]), 32'h24);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R3 winner", 32'(id), 2);
    check("R3 loser kept", 32'(status[N-1:0]), 32'h20);
    check("R8 gie cleared", 32'(status[SW-1]), 0);
    step('0, '0, 1'b1, 1'b1, 1'b0);
    check("R7 eoi over ack", 32'(active), 0);
    check("R8 gie set", 32'(status[SW-1]), 1);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R3 second", 32'(id), 5);
    step('0, '0, 1'b0, 1'b1, 1'b0);

    // R5 flat mode blocks even priority 0; R10 drain order
    step(8'h80, '0, 1'b0, 1'b0, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    step(8'h4b, '0, 1'b0, 1'b0, 1'b0);
    check("R5 flat quiet", 32'(irq), 0);
    step('0, '0, 1'b0, 1'b1, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R10 first", 32'(id), 0);
    step('0, '0, 1'b0, 1'b1, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R10 second", 32'(id), 1);
    step('0, '0, 1'b0, 1'b1, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R10 third", 32'(id), 3);
    step('0, '0, 1'b0, 1'b1, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    check("R10 fourth", 32'(id), 6);
    step('0, '0, 1'b0, 1'b1, 1'b0);

    // R6 nesting: equal/lower wait, higher pre-empts, R7 resume
    step(8'h10, '0, 1'b0, 1'b0, 1'b1);
    step('0, '0, 1'b1, 1'b0, 1'b1);
    step(8'h50, '0, 1'b0, 1'b0, 1'b1);
    check("R6 equal/lower wait", 32'(irq), 0);
    step(8'h02, '0, 1'b0, 1'b0, 1'b1);
    check("R6 higher raises", 32'(irq), 1);
    step('0, '0, 1'b1, 1'b0, 1'b1);
    check("R6 nested id", 32'(id), 1);
    step('0, '0, 1'b0, 1'b1, 1'b1);
    check("R7 resume", 32'(id), 4);
    check("R8 gie still low", 32'(status[SW-1]), 0);
    step('0, '0, 1'b0, 1'b1, 1'b1);
    check("R8 gie back", 32'(status[SW-1]), 1);
    repeat (4) begin
      step('0, '0, 1'b1, 1'b0, 1'b1);
      step('0, '0, 1'b0, 1'b1, 1'b1);
    end

    // random mix, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] rq;
      rq = N'($urandom) & N'($urandom) & N'($urandom);
      step(rq, N'($urandom) & N'($urandom),
           1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
           1'((i / 500) % 2));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule